// File: doc/BRIEF.md
# AXI Response Latency Enforcer

This block sits on the control wires of an AXI link between a master and a memory. It makes sure that read data and write responses never reach the master sooner than a programmed minimum number of clock cycles after the request they belong to. The read and write minimums are separate 12-bit run-time inputs.

A free-running cycle counter stamps each read when its address handshake completes, and each write when the handshake of its final data beat completes. The stamps wait in two small FIFOs. The head stamp of each FIFO decides when the first beat of the matching read burst, or the matching write response, may pass to the master.

A response that the memory delivers after its deadline is forwarded at once. In the same cycle a single-cycle underrun pulse reports the missed deadline, with one pulse output for reads and one for writes. Address, data and response payload wires run straight between the two sides; only VALID, READY and LAST pass through this block.

Top module: `resp_latency_gate`

## Requirements
- R1: After reset both stamp FIFOs are empty. The address and write-data paths are then open, no response reaches the master, and neither underrun output is high.
- R2: The first R beat of a read burst reaches the master (up_rvalid) only once the age of the oldest read stamp is at least rd_min_lat cycles. Age is the number of clock edges since the read address handshake.
- R3: A write response reaches the master (up_bvalid) only once the age of the oldest write stamp is at least wr_min_lat cycles. The stamp is taken at the handshake of the W beat that has up_wlast high.
- R4: When the memory presents a response whose deadline has already been reached, the response is forwarded in the same cycle, with no extra delay.
- R5: R beats after the first beat of a burst pass with plain handshaking and are never held. The burst ends on the beat with dn_rlast high.
- R6: rd_underrun is high for exactly one cycle when the first beat of a read burst first appears from memory while the head stamp's age is greater than rd_min_lat.
- R7: wr_underrun is high for exactly one cycle when a write response first appears from memory while the head stamp's age is greater than wr_min_lat.
- R8: While the read stamp FIFO holds RD_DEPTH entries, up_arready and dn_arvalid are low.
- R9: While the write stamp FIFO holds WR_DEPTH entries, up_wready and dn_wvalid are low.
- R10: Once up_rvalid or up_bvalid is high, it stays high until the matching READY from the master is high, provided the memory holds its VALID.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_min_lat | input | 12 | Minimum read latency in cycles |
| wr_min_lat | input | 12 | Minimum write response latency in cycles |
| up_arvalid | input | 1 | Read address valid from master |
| up_arready | output | 1 | Read address ready to master |
| dn_arvalid | output | 1 | Read address valid to memory |
| dn_arready | input | 1 | Read address ready from memory |
| up_wvalid | input | 1 | Write data valid from master |
| up_wlast | input | 1 | Final write beat marker from master |
| up_wready | output | 1 | Write data ready to master |
| dn_wvalid | output | 1 | Write data valid to memory |
| dn_wready | input | 1 | Write data ready from memory |
| dn_rvalid | input | 1 | Read data valid from memory |
| dn_rlast | input | 1 | Final read beat marker from memory |
| dn_rready | output | 1 | Read data ready to memory |
| up_rvalid | output | 1 | Read data valid to master |
| up_rready | input | 1 | Read data ready from master |
| dn_bvalid | input | 1 | Write response valid from memory |
| dn_bready | output | 1 | Write response ready to memory |
| up_bvalid | output | 1 | Write response valid to master |
| up_bready | input | 1 | Write response ready from master |
| rd_underrun | output | 1 | Read deadline missed pulse |
| wr_underrun | output | 1 | Write deadline missed pulse |

## Verification
Every gated output is a combinational function of the current inputs and of registered stamp state. A stamp taken at a handshake edge becomes the FIFO head one cycle later, with age 1. Forwarding, stalling and underrun flags are therefore due in the same cycle as the memory or master input that causes them. The bench drives all inputs on the falling edge and compares every output one nanosecond later against a behavioural model. That model keeps integer timestamps in queues and advances its state once per rising edge, so each expected value is computed in exactly the cycle the design produces it.

// File: rtl/rlat_pkg.sv
package rlat_pkg;

    localparam int LAT_W   = 12;
    localparam int STAMP_W = LAT_W + 4;

    typedef logic [LAT_W-1:0]   lat_t;
    typedef logic [STAMP_W-1:0] stamp_t;

    typedef enum logic {
        BEAT_LEAD  = 1'b0,
        BEAT_TRAIL = 1'b1
    } beat_e;

    function automatic stamp_t stamp_age(stamp_t now, stamp_t then);
        return now - then;
    endfunction

    function automatic logic age_reached(stamp_t age, lat_t lat);
        return age >= stamp_t'(lat);
    endfunction

    function automatic logic age_past(stamp_t age, lat_t lat);
        return age > stamp_t'(lat);
    endfunction

endpackage

// File: rtl/stamp_fifo.sv
module stamp_fifo
    import rlat_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   push,
    input  stamp_t din,
    input  logic   pop,
    output logic   full,
    output logic   nonempty,
    output stamp_t head
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] LAST_IDX = PW'(DEPTH - 1);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    stamp_t          store [DEPTH];
    logic [PW-1:0]   wr_idx, rd_idx;
    logic [CW-1:0]   count;

    assign full     = (count == FULL_CNT);
    assign nonempty = (count != '0);
    assign head     = store[rd_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_idx <= '0;
            rd_idx <= '0;
            count  <= '0;
        end else begin
            if (push) begin
                store[wr_idx] <= din;
                wr_idx <= (wr_idx == LAST_IDX) ? '0 : wr_idx + 1'b1;
            end
            if (pop) begin
                rd_idx <= (rd_idx == LAST_IDX) ? '0 : rd_idx + 1'b1;
            end
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R8
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        full |-> !push);

    // R2
    no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
        pop |-> nonempty);

endmodule

// File: rtl/resp_gate.sv
module resp_gate
    import rlat_pkg::*;
#(
    parameter bit BURST = 1'b1
) (
    input  logic   clk,
    input  logic   rst,
    input  stamp_t now,
    input  lat_t   lat,
    input  stamp_t head,
    input  logic   head_ok,
    input  logic   dn_valid,
    input  logic   dn_last,
    input  logic   up_ready,
    output logic   up_valid,
    output logic   dn_ready,
    output logic   pop,
    output logic   late
);
    beat_e  beat;
    logic   seen;
    stamp_t age;
    logic   lead, open_gate, hs;

    assign age       = stamp_age(now, head);
    assign lead      = (beat == BEAT_LEAD);
    assign open_gate = !lead || (head_ok && age_reached(age, lat));
    assign up_valid  = dn_valid && open_gate;
    assign dn_ready  = up_ready && open_gate;
    assign hs        = dn_valid && dn_ready;
    assign pop       = hs && lead;
    assign late      = dn_valid && lead && !seen && head_ok && age_past(age, lat);

    generate
        if (BURST) begin : g_burst
            always_ff @(posedge clk) begin
                if (rst)     beat <= BEAT_LEAD;
                else if (hs) beat <= dn_last ? BEAT_LEAD : BEAT_TRAIL;
            end
        end else begin : g_single
            logic unused_last;
            assign unused_last = dn_last;
            assign beat = BEAT_LEAD;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst)                   seen <= 1'b0;
        else if (hs)               seen <= 1'b0;
        else if (dn_valid && lead) seen <= 1'b1;
    end

    // R10
    hold_valid_chk: assert property (@(posedge clk) disable iff (rst)
        (up_valid && !up_ready && dn_valid) |=> (up_valid || !dn_valid));

    // R6
    late_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        (late && !dn_ready) |=> !late);

    // R2
    head_needed_chk: assert property (@(posedge clk) disable iff (rst)
        (up_valid && lead) |-> head_ok);

endmodule

// File: rtl/resp_latency_gate.sv
module resp_latency_gate
    import rlat_pkg::*;
#(
    parameter int RD_DEPTH = 8,
    parameter int WR_DEPTH = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [11:0] rd_min_lat,
    input  logic [11:0] wr_min_lat,
    input  logic        up_arvalid,
    output logic        up_arready,
    output logic        dn_arvalid,
    input  logic        dn_arready,
    input  logic        up_wvalid,
    input  logic        up_wlast,
    output logic        up_wready,
    output logic        dn_wvalid,
    input  logic        dn_wready,
    input  logic        dn_rvalid,
    input  logic        dn_rlast,
    output logic        dn_rready,
    output logic        up_rvalid,
    input  logic        up_rready,
    input  logic        dn_bvalid,
    output logic        dn_bready,
    output logic        up_bvalid,
    input  logic        up_bready,
    output logic        rd_underrun,
    output logic        wr_underrun
);
    stamp_t now_q;
    logic   rd_full, rd_ne, rd_push, rd_pop;
    logic   wr_full, wr_ne, wr_push, wr_pop;
    stamp_t rd_head, wr_head;

    always_ff @(posedge clk) begin
        if (rst) now_q <= '0;
        else     now_q <= now_q + 1'b1;
    end

    assign up_arready = dn_arready && !rd_full;
    assign dn_arvalid = up_arvalid && !rd_full;
    assign rd_push    = up_arvalid && up_arready;

    assign up_wready  = dn_wready && !wr_full;
    assign dn_wvalid  = up_wvalid && !wr_full;
    assign wr_push    = up_wvalid && up_wready && up_wlast;

    stamp_fifo #(.DEPTH(RD_DEPTH)) u_rd_fifo (
        .clk(clk), .rst(rst), .push(rd_push), .din(now_q), .pop(rd_pop),
        .full(rd_full), .nonempty(rd_ne), .head(rd_head)
    );

    stamp_fifo #(.DEPTH(WR_DEPTH)) u_wr_fifo (
        .clk(clk), .rst(rst), .push(wr_push), .din(now_q), .pop(wr_pop),
        .full(wr_full), .nonempty(wr_ne), .head(wr_head)
    );

    resp_gate #(.BURST(1'b1)) u_r_gate (
        .clk(clk), .rst(rst), .now(now_q), .lat(rd_min_lat),
        .head(rd_head), .head_ok(rd_ne),
        .dn_valid(dn_rvalid), .dn_last(dn_rlast), .up_ready(up_rready),
        .up_valid(up_rvalid), .dn_ready(dn_rready), .pop(rd_pop), .late(rd_underrun)
    );

    resp_gate #(.BURST(1'b0)) u_b_gate (
        .clk(clk), .rst(rst), .now(now_q), .lat(wr_min_lat),
        .head(wr_head), .head_ok(wr_ne),
        .dn_valid(dn_bvalid), .dn_last(1'b1), .up_ready(up_bready),
        .up_valid(up_bvalid), .dn_ready(dn_bready), .pop(wr_pop), .late(wr_underrun)
    );

    // R9
    w_stall_chk: assert property (@(posedge clk) disable iff (rst)
        wr_full |-> !wr_push);

    // R7
    b_late_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
        wr_underrun |-> (dn_bvalid && wr_ne));

endmodule

// File: tb/tb_resp_latency_gate.sv
module tb_resp_latency_gate;
    localparam int CLK_NS = 10;
    localparam int DEPTH  = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [11:0] rd_min_lat = '0, wr_min_lat = '0;
    logic up_arvalid = 0, dn_arready = 0, up_wvalid = 0, up_wlast = 0, dn_wready = 0;
    logic dn_rvalid = 0, dn_rlast = 0, up_rready = 0, dn_bvalid = 0, up_bready = 0;
    logic up_arready, dn_arvalid, up_wready, dn_wvalid, dn_rready, up_rvalid;
    logic dn_bready, up_bvalid, rd_underrun, wr_underrun;

    always #(CLK_NS/2) clk = ~clk;

    resp_latency_gate #(.RD_DEPTH(DEPTH), .WR_DEPTH(DEPTH)) dut (
        .clk(clk), .rst(rst), .rd_min_lat(rd_min_lat), .wr_min_lat(wr_min_lat),
        .up_arvalid(up_arvalid), .up_arready(up_arready), .dn_arvalid(dn_arvalid),
        .dn_arready(dn_arready), .up_wvalid(up_wvalid), .up_wlast(up_wlast),
        .up_wready(up_wready), .dn_wvalid(dn_wvalid), .dn_wready(dn_wready),
        .dn_rvalid(dn_rvalid), .dn_rlast(dn_rlast), .dn_rready(dn_rready),
        .up_rvalid(up_rvalid), .up_rready(up_rready), .dn_bvalid(dn_bvalid),
        .dn_bready(dn_bready), .up_bvalid(up_bvalid), .up_bready(up_bready),
        .rd_underrun(rd_underrun), .wr_underrun(wr_underrun)
    );

    int n_chk = 0, n_bad = 0, cyc = 0, gcyc = 0;
    int rts[$], wts[$];
    int mr_arr[$], mr_len[$], mb_arr[$];
    int mr_beat = 0;
    bit rtail = 0, rseen = 0, bseen = 0, r_stalled = 0, b_stalled = 0;
    int rd_left = 0, rd_idx = 0, wr_left = 0, wr_idx = 0, wbeat = 0;
    int rlat = 0, wlat = 0, dbase = 0, rmode = 0;

    task automatic chk(string tag, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s at cycle %0d: actual %b expected %b", tag, cyc, act, exp);
        end
    endtask

    function automatic int rdly(int k);
        case (k % 4)
            0: return 2;
            1: return dbase;
            2: return 1;
            default: return dbase * 2 + 3;
        endcase
    endfunction
    function automatic int rlen(int k); return (k % 3) + 1; endfunction
    function automatic int wlen(int k); return (k % 2) + 1; endfunction
    function automatic int bdly(int k);
        case (k % 3)
            0: return 1;
            1: return dbase;
            default: return dbase * 2;
        endcase
    endfunction

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    task automatic step();
        bit rfull, wfull, e_arready, e_darv, e_wready, e_dwv, r_ok, b_ok;
        bit e_urv, e_drr, e_rlate, e_ubv, e_dbr, e_blate, rhead, bhead;
        int rage, bage;
        string rtag, btag;
        @(negedge clk);
        gcyc++;
        if (gcyc > 150000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            finish_run();
        end
        up_arvalid = (rd_left > 0);
        dn_arready = (rmode == 2) ? ((cyc % 4) != 0) : 1'b1;
        up_wvalid  = (wr_left > 0);
        up_wlast   = (wbeat == wlen(wr_idx) - 1);
        dn_wready  = 1'b1;
        dn_rvalid  = (mr_arr.size() > 0) && (cyc >= mr_arr[0]);
        dn_rlast   = dn_rvalid && (mr_beat == mr_len[0] - 1);
        dn_bvalid  = (mb_arr.size() > 0) && (cyc >= mb_arr[0]);
        up_rready  = (rmode == 0) ? 1'b1 : ((cyc % 5) != 2);
        up_bready  = (rmode == 0) ? 1'b1 : ((cyc % 3) != 1);
        #1;
        rfull = rts.size() >= DEPTH;
        wfull = wts.size() >= DEPTH;
        e_arready = dn_arready && !rfull;
        e_darv    = up_arvalid && !rfull;
        e_wready  = dn_wready && !wfull;
        e_dwv     = up_wvalid && !wfull;
        rhead = rts.size() > 0;
        rage  = rhead ? cyc - rts[0] : 0;
        bhead = wts.size() > 0;
        bage  = bhead ? cyc - wts[0] : 0;
        r_ok  = rtail || (rhead && rage >= rlat);
        b_ok  = bhead && bage >= wlat;
        e_urv = dn_rvalid && r_ok;
        e_drr = up_rready && r_ok;
        e_ubv = dn_bvalid && b_ok;
        e_dbr = up_bready && b_ok;
        e_rlate = dn_rvalid && !rtail && !rseen && rhead && rage > rlat;
        e_blate = dn_bvalid && !bseen && bhead && bage > wlat;
        rtag = r_stalled ? "R10 up_rvalid" : rtail ? "R5 up_rvalid" :
               (rhead && rage > rlat) ? "R4 up_rvalid" : "R2 up_rvalid";
        btag = b_stalled ? "R10 up_bvalid" :
               (bhead && bage > wlat) ? "R4 up_bvalid" : "R3 up_bvalid";
        chk("R8 up_arready", up_arready, e_arready);
        chk("R8 dn_arvalid", dn_arvalid, e_darv);
        chk("R9 up_wready", up_wready, e_wready);
        chk("R9 dn_wvalid", dn_wvalid, e_dwv);
        chk(rtag, up_rvalid, e_urv);
        chk("R2 dn_rready", dn_rready, e_drr);
        chk(btag, up_bvalid, e_ubv);
        chk("R3 dn_bready", dn_bready, e_dbr);
        chk("R6 rd_underrun", rd_underrun, e_rlate);
        chk("R7 wr_underrun", wr_underrun, e_blate);
        // model state advance for the coming edge
        if (up_arvalid && e_arready) begin
            rts.push_back(cyc);
            mr_arr.push_back(cyc + rdly(rd_idx));
            mr_len.push_back(rlen(rd_idx));
            rd_left--; rd_idx++;
        end
        if (dn_rvalid && e_drr) begin
            if (!rtail) void'(rts.pop_front());
            rseen = 0;
            rtail = !dn_rlast;
            if (dn_rlast) begin
                void'(mr_arr.pop_front()); void'(mr_len.pop_front()); mr_beat = 0;
            end else mr_beat++;
        end else if (dn_rvalid && !rtail) rseen = 1;
        if (up_wvalid && e_wready) begin
            if (up_wlast) begin
                wts.push_back(cyc);
                mb_arr.push_back(cyc + bdly(wr_idx));
                wr_left--; wr_idx++; wbeat = 0;
            end else wbeat++;
        end
        if (dn_bvalid && e_dbr) begin
            void'(wts.pop_front()); void'(mb_arr.pop_front()); bseen = 0;
        end else if (dn_bvalid) bseen = 1;
        r_stalled = e_urv && !up_rready;
        b_stalled = e_ubv && !up_bready;
        cyc++;
    endtask

    task automatic run_phase(int rl, int wl, int nrd, int nwr, int db, int md);
        int guard = 0;
        rlat = rl; wlat = wl; dbase = db; rmode = md;
        rd_min_lat = 12'(rl); wr_min_lat = 12'(wl);
        rd_left = nrd; wr_left = nwr;
        while ((rd_left > 0 || wr_left > 0 || mr_arr.size() > 0 || mb_arr.size() > 0)
               && guard < 5000) begin
            step();
            guard++;
        end
        for (int i = 0; i < 3; i++) step();
    endtask

    initial begin
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state, memory offers an unrequested read beat
        dn_arready = 1'b1; up_arvalid = 1'b1; dn_wready = 1'b1; up_wvalid = 1'b1;
        dn_rvalid = 1'b1; dn_bvalid = 1'b1; up_rready = 1'b1; up_bready = 1'b1;
        #1;
        chk("R1 up_arready", up_arready, 1'b1);
        chk("R1 up_wready", up_wready, 1'b1);
        chk("R1 up_rvalid", up_rvalid, 1'b0);
        chk("R1 up_bvalid", up_bvalid, 1'b0);
        chk("R1 rd_underrun", rd_underrun, 1'b0);
        chk("R1 wr_underrun", wr_underrun, 1'b0);
        up_arvalid = 0; up_wvalid = 0; dn_rvalid = 0; dn_bvalid = 0;
        @(posedge clk);
        run_phase(10, 8, 12, 12, 12, 0);
        run_phase(20, 25, 16, 16, 4, 1);
        run_phase(5, 3, 16, 16, 40, 2);
        run_phase(0, 0, 10, 10, 2, 1);
        run_phase(15, 30, 14, 14, 9, 2);
        finish_run();
    end
endmodule